// File: doc/BRIEF.md
# PWM Passive-Level Clamp Controller

This block sits between a PWM generator and an output pin. It holds the pin at a chosen safe level while an external protection or control signal is asserted, and passes the PWM waveform through unchanged otherwise. One of sixteen control lines is picked as the trigger, and its active polarity is programmable. The output level used while clamped is also programmable.

A four-state controller decides when the clamp begins and when it ends. Entry and exit can each happen at once, or they can be held until a blanked comparator input makes a chosen transition. This lets the clamp line up with a current-sense event. A latch option keeps the clamp on after the trigger goes away until software sends a one-cycle release strobe. All settings come from a plain 32-bit configuration input. Its reset value of zero means that no clamping takes place.

Top module: `pwm_passive_clamp`

## Requirements
- R1: Outside the clamped and exit-wait states, `pwmOut` equals `pwmIn` in the same cycle.
- R2: `cfgWord[3:0]` selects which bit of `trigLines` acts as the trigger. Only that bit affects the clamp.
- R3: `cfgWord[9:8]` sets the trigger sense. 1 means the trigger is active while the selected line is HIGH, 2 means it is active while the line is LOW, and 0 or 3 disables clamping.
- R4: While clamped, `pwmOut` equals `cfgWord[10]` (0 = LOW, 1 = HIGH) whatever `pwmIn` does.
- R5: With entry code `cfgWord[13:12]` equal to 0 or 3, the output is clamped right after the first rising clock edge that samples an active trigger.
- R6: Entry code 1 waits for a falling edge of `cmpBlanked` and code 2 waits for a rising edge. The edge counts at the second clock edge after the input changes. A comparator that is already at the target level when the wait starts does not count.
- R7: If the trigger goes inactive during the entry wait, the controller returns to pass-through, even when the comparator edge arrives in the same cycle.
- R8: Exit code `cfgWord[15:14]` uses the entry encoding (0/3 immediate, 1 falling, 2 rising). The output stays clamped throughout the exit wait.
- R9: With `cfgWord[11]`=0, either the trigger going inactive or a `swRelease` strobe ends the clamp. With it set to 1, only `swRelease` ends it.
- R10: A release while the trigger is still active gives one cycle of pass-through, then the clamp starts again on the next edge.
- R11: Setting the sense code to disabled returns the controller to pass-through at the next clock edge, from any state.
- R12: A synchronous active-high `rst` returns the controller to pass-through and clears the comparator history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwmIn | input | 1 | PWM waveform to pass through |
| trigLines | input | 16 | Candidate clamp trigger lines |
| cmpBlanked | input | 1 | Blanked comparator output |
| swRelease | input | 1 | One-cycle software release strobe |
| cfgWord | input | 32 | Configuration word |
| pwmOut | output | 1 | PWM or passive level |

## Verification
The in-RTL assertions check four rules on every clock cycle: the disable override, the abort out of the entry wait, the latch holding against a dropped trigger, and the exit paths of the state machine. They also check that a comparator edge flag never lasts two cycles. The bench scenarios cover what needs a stimulus history. These are the two-edge comparator latency, ignoring a comparator already at its target level, re-entry after a release under an active trigger, the polarity and line selection, and the reserved codes.

// File: rtl/pwm_clamp_pkg.sv
package pwm_clamp_pkg;
  localparam int SEL_W      = 4;
  localparam int NUM_TRIG   = 1 << SEL_W;
  localparam int SEL_LSB    = 0;
  localparam int SENSE_LSB  = 8;
  localparam int LEVEL_BIT  = 10;
  localparam int SWONLY_BIT = 11;
  localparam int ENTER_LSB  = 12;
  localparam int EXIT_LSB   = 14;
  localparam int USED_MSB   = EXIT_LSB + 1;

  typedef enum logic [1:0] {
    SENSE_OFF  = 2'd0,
    SENSE_HIGH = 2'd1,
    SENSE_LOW  = 2'd2
  } sense_e;

  typedef enum logic [1:0] {
    COND_NOW  = 2'd0,
    COND_FALL = 2'd1,
    COND_RISE = 2'd2
  } cond_e;

  typedef enum logic [1:0] {
    ST_ACTIVE,
    ST_WAIT_ENTER,
    ST_CLAMPED,
    ST_WAIT_EXIT
  } clamp_state_e;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    sense_e           sense;
    logic             level;
    logic             swOnly;
    cond_e            enterCond;
    cond_e            exitCond;
  } clamp_cfg_t;

  typedef struct packed {
    logic trigActive;
    logic cmpRose;
    logic cmpFell;
  } dp_status_t;

  typedef struct packed {
    logic clampSel;
  } ctrl_strobe_t;

  // reserved code 3 folds onto the disabled sense
  function automatic sense_e toSense(input logic [1:0] code);
    case (code)
      2'd1:    return SENSE_HIGH;
      2'd2:    return SENSE_LOW;
      default: return SENSE_OFF;
    endcase
  endfunction

  // reserved code 3 folds onto the immediate condition
  function automatic cond_e toCond(input logic [1:0] code);
    case (code)
      2'd1:    return COND_FALL;
      2'd2:    return COND_RISE;
      default: return COND_NOW;
    endcase
  endfunction
endpackage

// File: rtl/pwm_clamp_datapath.sv
module pwm_clamp_datapath
  import pwm_clamp_pkg::*;
#(
  parameter int SEL_BITS = SEL_W,
  localparam int LINES   = 1 << SEL_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pwmIn,
  input  logic [LINES-1:0]    trigLines,
  input  logic                cmpBlanked,
  input  logic [SEL_BITS-1:0] trigSel,
  input  sense_e              trigSense,
  input  logic                passiveLevel,
  input  ctrl_strobe_t        strobe,
  output dp_status_t          status,
  output logic                pwmOut
);
  logic cmpNow, cmpPrev, selLine;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmpNow  <= 1'b0;
      cmpPrev <= 1'b0;
    end else begin
      cmpNow  <= cmpBlanked;
      cmpPrev <= cmpNow;
    end
  end

  assign selLine = trigLines[trigSel];

  always_comb begin
    unique case (trigSense)
      SENSE_HIGH: status.trigActive = selLine;
      SENSE_LOW:  status.trigActive = ~selLine;
      default:    status.trigActive = 1'b0;
    endcase
  end

  assign status.cmpRose = cmpNow & ~cmpPrev;
  assign status.cmpFell = ~cmpNow & cmpPrev;

  assign pwmOut = strobe.clampSel ? passiveLevel : pwmIn;

  // R6: a registered edge flag lasts exactly one cycle
  assert_rise_single_R6: assert property (@(posedge clk) disable iff (rst)
    status.cmpRose |=> !status.cmpRose);
  assert_fall_single_R6: assert property (@(posedge clk) disable iff (rst)
    status.cmpFell |=> !status.cmpFell);
endmodule

// File: rtl/pwm_clamp_ctrl.sv
module pwm_clamp_ctrl
  import pwm_clamp_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         senseOn,
  input  logic         swOnly,
  input  cond_e        enterCond,
  input  cond_e        exitCond,
  input  logic         swRelease,
  input  dp_status_t   status,
  output ctrl_strobe_t strobe
);
  clamp_state_e state, nextState;

  function automatic logic condHit(input cond_e c, input dp_status_t s);
    case (c)
      COND_FALL: return s.cmpFell;
      COND_RISE: return s.cmpRose;
      default:   return 1'b1;
    endcase
  endfunction

  always_comb begin
    nextState = state;
    if (!senseOn) begin
      nextState = ST_ACTIVE;
    end else begin
      unique case (state)
        ST_ACTIVE:
          if (status.trigActive)
            nextState = (enterCond == COND_NOW) ? ST_CLAMPED : ST_WAIT_ENTER;
        ST_WAIT_ENTER:
          if (!status.trigActive)
            nextState = ST_ACTIVE;
          else if (condHit(enterCond, status))
            nextState = ST_CLAMPED;
        ST_CLAMPED:
          if (swRelease || (!swOnly && !status.trigActive))
            nextState = (exitCond == COND_NOW) ? ST_ACTIVE : ST_WAIT_EXIT;
        ST_WAIT_EXIT:
          if (condHit(exitCond, status))
            nextState = ST_ACTIVE;
        default: nextState = ST_ACTIVE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_ACTIVE;
    else     state <= nextState;
  end

  assign strobe.clampSel = (state == ST_CLAMPED) || (state == ST_WAIT_EXIT);

  assert_disable_override_R11: assert property (@(posedge clk) disable iff (rst)
    !senseOn |=> state == ST_ACTIVE);
  assert_enter_abort_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_ENTER && !status.trigActive) |=> state == ST_ACTIVE);
  assert_latch_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CLAMPED && senseOn && swOnly && !swRelease) |=> state == ST_CLAMPED);
  assert_release_now_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CLAMPED && senseOn && swRelease && exitCond == COND_NOW)
      |=> state == ST_ACTIVE);
  assert_no_skip_exit_R8: assert property (@(posedge clk) disable iff (rst)
    state == ST_ACTIVE |=> state != ST_WAIT_EXIT);
endmodule

// File: rtl/pwm_passive_clamp.sv
module pwm_passive_clamp
  import pwm_clamp_pkg::*;
#(
  parameter int CFG_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pwmIn,
  input  logic [NUM_TRIG-1:0] trigLines,
  input  logic                cmpBlanked,
  input  logic                swRelease,
  input  logic [CFG_W-1:0]    cfgWord,
  output logic                pwmOut
);
  clamp_cfg_t   cfgDec;
  dp_status_t   status;
  ctrl_strobe_t strobe;
  logic         unusedCfgBits;

  assign cfgDec.sel       = cfgWord[SEL_LSB +: SEL_W];
  assign cfgDec.sense     = toSense(cfgWord[SENSE_LSB +: 2]);
  assign cfgDec.level     = cfgWord[LEVEL_BIT];
  assign cfgDec.swOnly    = cfgWord[SWONLY_BIT];
  assign cfgDec.enterCond = toCond(cfgWord[ENTER_LSB +: 2]);
  assign cfgDec.exitCond  = toCond(cfgWord[EXIT_LSB +: 2]);
  assign unusedCfgBits    = ^{cfgWord[CFG_W-1:USED_MSB+1], cfgWord[SENSE_LSB-1:SEL_LSB+SEL_W]};

  pwm_clamp_datapath #(.SEL_BITS(SEL_W)) uDatapath (
    .clk          (clk),
    .rst          (rst),
    .pwmIn        (pwmIn),
    .trigLines    (trigLines),
    .cmpBlanked   (cmpBlanked),
    .trigSel      (cfgDec.sel),
    .trigSense    (cfgDec.sense),
    .passiveLevel (cfgDec.level),
    .strobe       (strobe),
    .status       (status),
    .pwmOut       (pwmOut)
  );

  pwm_clamp_ctrl uCtrl (
    .clk       (clk),
    .rst       (rst),
    .senseOn   (cfgDec.sense != SENSE_OFF),
    .swOnly    (cfgDec.swOnly),
    .enterCond (cfgDec.enterCond),
    .exitCond  (cfgDec.exitCond),
    .swRelease (swRelease),
    .status    (status),
    .strobe    (strobe)
  );
endmodule

// File: tb/tb_pwm_passive_clamp.sv
`timescale 1ns/1ps
module tb_pwm_passive_clamp;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwmIn = 1'b0;
  logic [15:0] trigLines = '0;
  logic        cmpBlanked = 1'b0;
  logic        swRelease = 1'b0;
  logic [31:0] cfgWord = '0;
  logic        pwmOut;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pwm_passive_clamp dut (
    .clk(clk), .rst(rst), .pwmIn(pwmIn), .trigLines(trigLines),
    .cmpBlanked(cmpBlanked), .swRelease(swRelease), .cfgWord(cfgWord),
    .pwmOut(pwmOut)
  );

  // {req[3:0], cfg[15:0], lines[15:0], cmp, rel, pwm, expected}
  localparam int NV = 52;
  localparam logic [39:0] VEC [NV] = '{
    // R3 / R1: disabled sense passes pwm
    {4'd3, 16'h0000, 16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b1},
    {4'd1, 16'h0000, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0},
    // R5: immediate entry on line 3, HIGH sense, LOW level
    {4'd5, 16'h0103, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1},
    {4'd5, 16'h0103, 16'h0008, 1'b0, 1'b0, 1'b1, 1'b0},
    {4'd5, 16'h0103, 16'h0008, 1'b0, 1'b0, 1'b1, 1'b0},
    {4'd9, 16'h0103, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1},
    {4'd2, 16'h0103, 16'hFFF7, 1'b0, 1'b0, 1'b1, 1'b1},
    // R2: line 15 selected
    {4'd2, 16'h010F, 16'h7FFF, 1'b0, 1'b0, 1'b1, 1'b1},
    {4'd2, 16'h010F, 16'h8000, 1'b0, 1'b0, 1'b1, 1'b0},
    {4'd2, 16'h010F, 16'h7FFF, 1'b0, 1'b0, 1'b1, 1'b1},
    // R3 / R4: LOW sense on line 5, HIGH level
    {4'd3, 16'h0605, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'd4, 16'h0605, 16'hFFDF, 1'b0, 1'b0, 1'b0, 1'b1},
    {4'd3, 16'h0605, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0},
    // R6: entry waits for comparator rise, two-edge latency
    {4'd6, 16'h2500, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'd6, 16'h2500, 16'h0001, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'd6, 16'h2500, 16'h0001, 1'b1, 1'b0, 1'b0, 1'b1},
    {4'd9, 16'h2500, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0},
    // R6: comparator already high, a fall is ignored, next rise counts
    {4'd6, 16'h2500, 16'h0001, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'd6, 16'h2500, 16'h0001, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'd6, 16'h2500, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'd6, 16'h2500, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'd6, 16'h2500, 16'h0001, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'd6, 16'h2500, 16'h0001, 1'b1, 1'b0, 1'b0, 1'b1},
    {4'd9, 16'h2500, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0},
    // R7: trigger drop beats a same-cycle comparator rise
    {4'd7, 16'h2500, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'd7, 16'h2500, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'd7, 16'h2500, 16'h0001, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'd7, 16'h2500, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'd7, 16'h2500, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0},
    // R8: exit waits for comparator fall, output held
    {4'd8, 16'h4502, 16'h0004, 1'b1, 1'b0, 1'b0, 1'b1},
    {4'd8, 16'h4502, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1},
    {4'd8, 16'h4502, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1},
    {4'd8, 16'h4502, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1},
    {4'd8, 16'h4502, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0},
    // R9: latched, only release ends it
    {4'd9, 16'h0902, 16'h0004, 1'b0, 1'b0, 1'b1, 1'b0},
    {4'd9, 16'h0902, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0},
    {4'd9, 16'h0902, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0},
    {4'd9, 16'h0902, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1},
    {4'd9, 16'h0902, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1},
    // R10: release under active trigger re-enters
    {4'd10, 16'h0902, 16'h0004, 1'b0, 1'b0, 1'b1, 1'b0},
    {4'd10, 16'h0902, 16'h0004, 1'b0, 1'b1, 1'b1, 1'b1},
    {4'd10, 16'h0902, 16'h0004, 1'b0, 1'b0, 1'b1, 1'b0},
    {4'd9,  16'h0902, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1},
    // R11: disabling sense from clamped, reserved sense 3
    {4'd11, 16'h0902, 16'h0004, 1'b0, 1'b0, 1'b1, 1'b0},
    {4'd11, 16'h0802, 16'h0004, 1'b0, 1'b0, 1'b1, 1'b1},
    {4'd3,  16'h0B02, 16'h0004, 1'b0, 1'b0, 1'b1, 1'b1},
    // R5 / R6: reserved entry code 3 is immediate
    {4'd6, 16'h3102, 16'h0004, 1'b0, 1'b0, 1'b1, 1'b0},
    {4'd6, 16'h3102, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1},
    // R8 / R9: latched release then wait for comparator rise
    {4'd8, 16'h8D02, 16'h0004, 1'b0, 1'b0, 1'b0, 1'b1},
    {4'd8, 16'h8D02, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1},
    {4'd8, 16'h8D02, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1},
    {4'd8, 16'h8D02, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s at %0t: pwmOut=%b expected=%b", req, $time, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL R12 watchdog: actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    // R12: output follows pwm under and right after reset
    pwmIn = 1'b1; step();
    chk("R12", pwmOut, 1'b1);
    pwmIn = 1'b0; step();
    chk("R12", pwmOut, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      cfgWord    = {16'h0000, VEC[i][35:20]};
      trigLines  = VEC[i][19:4];
      cmpBlanked = VEC[i][3];
      swRelease  = VEC[i][2];
      pwmIn      = VEC[i][1];
      step();
      chk($sformatf("R%0d row %0d", VEC[i][39:36], i), pwmOut, VEC[i][0]);
    end
    swRelease  = 1'b0;
    cmpBlanked = 1'b0;

    // R4: level held while pwm toggles
    cfgWord   = 32'h0000_0503;
    trigLines = 16'h0008;
    for (int k = 0; k < 4; k++) begin
      pwmIn = k[0];
      step();
      chk("R4", pwmOut, 1'b1);
    end

    // R12: reset from clamped state returns to pass-through
    cfgWord = 32'h0000_0103;
    pwmIn   = 1'b1;
    step();
    chk("R5", pwmOut, 1'b0);
    rst = 1'b1;
    step();
    chk("R12", pwmOut, 1'b1);
    rst = 1'b0;
    trigLines = 16'h0000;
    step();
    chk("R12", pwmOut, 1'b1);

    // R2 / R3: upper configuration bits carry no meaning
    cfgWord   = 32'hFFFF_00F3;
    trigLines = 16'h0008;
    pwmIn     = 1'b1;
    step();
    chk("R3", pwmOut, 1'b1);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule